// File: doc/BRIEF.md
# Floating-Point Compare-to-Flags Unit

This unit compares two 80-bit extended-precision operands, the register on top of the floating-point stack (operand A) and a selected stack register (operand B). The result goes to three integer condition flags (zero, parity, carry). Each operand is classified as zero, normal, denormal, infinity, quiet NaN, signalling NaN or unsupported encoding. The unit then orders them by sign and magnitude, decides whether an invalid-operand exception is raised, and gates the flag write with the invalid-operation mask bit.

Two compare flavours share the datapath. The ordered flavour treats every NaN as invalid. The unordered flavour lets quiet NaNs through silently. Either flavour may also request a stack pop: it asks for the old top register to be tagged empty and for the top pointer to advance. Every result, including a request to clear the overflow flag and status bit C1, is registered and appears one cycle after the input strobe, together with a done pulse.

Top module: `fcmp_flags_unit`

## Requirements
- R1: When written, the flags {zf_o,pf_o,cf_o} are 3'b000 for A greater than B, 3'b001 for A less than B, 3'b100 for equal, and 3'b111 for unordered.
- R2: Positive zero and negative zero compare equal (3'b100) in either order.
- R3: With unord_i=0 (ordered flavour), a quiet NaN, signalling NaN or unsupported operand raises ia_o.
- R4: With unord_i=1, a quiet NaN operand gives 3'b111 with ia_o low; a signalling NaN or unsupported operand raises ia_o.
- R5: On an exception (ia_o or is_o), flags_we_o equals inv_mask_i: 0 leaves the flags unwritten, 1 writes 3'b111.
- R6: Each completed compare pulses of_clr_o and c1_clr_o, whether or not an exception occurs.
- R7: With pop_i=1, pop_o is raised, empty_idx_o equals top_i, and top_o equals top_i+1 modulo 8.
- R8: underflow_i=1 raises is_o instead of ia_o. The flags are gated as in R5.
- R9: Classification uses the explicit integer bit (bit 63), the exponent (bits 78:64) and the sign (bit 79). A nonzero exponent with bit 63 clear is unsupported. At the maximum exponent with bit 63 set, fraction bit 62 set is a quiet NaN, a zero fraction is infinity, and otherwise the operand is a signalling NaN.
- R10: All outputs register one cycle after valid_i, with done_o high for that cycle only. No write, pop or exception appears in a cycle without a preceding valid_i.
- R11: Denormals, normals and infinities order by magnitude, and the order is reversed when both operands are negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Compare request strobe |
| op_a_i | input | 80 | Stack-top operand |
| op_b_i | input | 80 | Selected stack register operand |
| unord_i | input | 1 | 1 = unordered flavour (quiet NaNs silent) |
| pop_i | input | 1 | 1 = pop the stack after comparing |
| inv_mask_i | input | 1 | Invalid-operation mask, 1 = masked |
| underflow_i | input | 1 | An operand register is empty |
| top_i | input | 3 | Current top-of-stack pointer |
| done_o | output | 1 | Result valid pulse |
| flags_we_o | output | 1 | Write enable for zf/pf/cf |
| zf_o | output | 1 | Zero flag value |
| pf_o | output | 1 | Parity flag value |
| cf_o | output | 1 | Carry flag value |
| of_clr_o | output | 1 | Clear the overflow flag |
| c1_clr_o | output | 1 | Clear status bit C1 |
| ia_o | output | 1 | Invalid-operand exception |
| is_o | output | 1 | Stack-underflow exception |
| pop_o | output | 1 | Pop request |
| top_o | output | 3 | New top-of-stack pointer |
| empty_idx_o | output | 3 | Register index to tag empty |

## Verification
A misclassified operand shows on the very next done_o in one of two ways. The flags leave the 3'b111 code they should have taken, or ia_o differs between the two flavours where it should not. A wrong sign or magnitude path swaps 3'b000 and 3'b001, which is most visible on negative pairs and on denormal pairs. Broken mask gating appears as flags_we_o disagreeing with inv_mask_i in the same cycle as the exception. Because nothing is held across compares, every fault surfaces one cycle after the strobe that exposes it.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int unsigned EXP_W = 15;
  localparam int unsigned SIG_W = 64;
  localparam int unsigned TOP_W = 3;

  typedef enum logic [2:0] {
    CLS_ZERO, CLS_NORM, CLS_DENORM, CLS_INF, CLS_QNAN, CLS_SNAN, CLS_UNSUP
  } fp_class_e;

  typedef enum logic [1:0] {
    REL_GT, REL_LT, REL_EQ
  } rel_e;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned SW = SIG_W,
  localparam int unsigned FW = EW + SW + 1,
  localparam int unsigned MW = EW + SW
) (
  input  logic [FW-1:0] op_i,
  output fp_class_e     cls_o,
  output logic          sign_o,
  output logic [MW-1:0] mag_o
);
  logic [EW-1:0] exp_f;
  logic [SW-1:0] sig_f;
  logic [EW-1:0] exp_eff;

  assign exp_f  = op_i[FW-2 -: EW];
  assign sig_f  = op_i[SW-1:0];
  assign sign_o = op_i[FW-1];

  always_comb begin
    if (exp_f == '0) begin
      cls_o = (sig_f == '0) ? CLS_ZERO : CLS_DENORM;
    end else if (exp_f == '1) begin
      if (!sig_f[SW-1])                cls_o = CLS_UNSUP;
      else if (sig_f[SW-2:0] == '0)    cls_o = CLS_INF;
      else if (sig_f[SW-2])            cls_o = CLS_QNAN;
      else                             cls_o = CLS_SNAN;
    end else begin
      cls_o = sig_f[SW-1] ? CLS_NORM : CLS_UNSUP;
    end
  end

  // denormals share the scale of exponent 1, so a flat unsigned compare orders them
  assign exp_eff = (exp_f == '0) ? EW'(1) : exp_f;
  assign mag_o   = {exp_eff, sig_f};
endmodule

// File: rtl/fcmp_magcmp.sv
module fcmp_magcmp
  import fcmp_pkg::*;
#(
  parameter int unsigned MW = EXP_W + SIG_W
) (
  input  logic          sign_a_i,
  input  logic          sign_b_i,
  input  logic          zero_a_i,
  input  logic          zero_b_i,
  input  logic [MW-1:0] mag_a_i,
  input  logic [MW-1:0] mag_b_i,
  output rel_e          rel_o
);
  logic mag_gt, mag_lt;

  assign mag_gt = mag_a_i > mag_b_i;
  assign mag_lt = mag_a_i < mag_b_i;

  always_comb begin
    if (zero_a_i && zero_b_i)      rel_o = REL_EQ;
    else if (sign_a_i != sign_b_i) rel_o = sign_b_i ? REL_GT : REL_LT;
    else if (!mag_gt && !mag_lt)   rel_o = REL_EQ;
    else if (sign_a_i)             rel_o = mag_gt ? REL_LT : REL_GT;
    else                           rel_o = mag_gt ? REL_GT : REL_LT;
  end
endmodule

// File: rtl/fcmp_flags_unit.sv
module fcmp_flags_unit
  import fcmp_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned SW = SIG_W,
  parameter int unsigned TW = TOP_W,
  localparam int unsigned FW = EW + SW + 1,
  localparam int unsigned MW = EW + SW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [FW-1:0] op_a_i,
  input  logic [FW-1:0] op_b_i,
  input  logic          unord_i,
  input  logic          pop_i,
  input  logic          inv_mask_i,
  input  logic          underflow_i,
  input  logic [TW-1:0] top_i,
  output logic          done_o,
  output logic          flags_we_o,
  output logic          zf_o,
  output logic          pf_o,
  output logic          cf_o,
  output logic          of_clr_o,
  output logic          c1_clr_o,
  output logic          ia_o,
  output logic          is_o,
  output logic          pop_o,
  output logic [TW-1:0] top_o,
  output logic [TW-1:0] empty_idx_o
);
  logic [FW-1:0] ops   [2];
  fp_class_e     cls   [2];
  logic          sgn   [2];
  logic [MW-1:0] mag   [2];
  logic          is_q  [2];
  logic          is_s  [2];
  logic          is_u  [2];

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_cls
    fcmp_classify #(.EW(EW), .SW(SW)) u_cls (
      .op_i  (ops[g]),
      .cls_o (cls[g]),
      .sign_o(sgn[g]),
      .mag_o (mag[g])
    );
    assign is_q[g] = cls[g] == CLS_QNAN;
    assign is_s[g] = cls[g] == CLS_SNAN;
    assign is_u[g] = cls[g] == CLS_UNSUP;
  end

  rel_e rel;
  fcmp_magcmp #(.MW(MW)) u_mag (
    .sign_a_i(sgn[0]),
    .sign_b_i(sgn[1]),
    .zero_a_i(cls[0] == CLS_ZERO),
    .zero_b_i(cls[1] == CLS_ZERO),
    .mag_a_i (mag[0]),
    .mag_b_i (mag[1]),
    .rel_o   (rel)
  );

  logic any_q, any_bad, unordered, ia_d, exc_d, we_d;
  logic [2:0] flags_d;

  assign any_q     = is_q[0] | is_q[1];
  assign any_bad   = is_s[0] | is_s[1] | is_u[0] | is_u[1];
  assign unordered = any_q | any_bad;
  // underflow takes precedence over operand checks
  assign ia_d      = !underflow_i && (unord_i ? any_bad : unordered);
  assign exc_d     = ia_d | underflow_i;
  assign we_d      = !exc_d | inv_mask_i;

  always_comb begin
    if (exc_d || unordered) flags_d = 3'b111;
    else begin
      unique case (rel)
        REL_GT:  flags_d = 3'b000;
        REL_LT:  flags_d = 3'b001;
        default: flags_d = 3'b100;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o      <= 1'b0;
      flags_we_o  <= 1'b0;
      {zf_o, pf_o, cf_o} <= 3'b000;
      of_clr_o    <= 1'b0;
      c1_clr_o    <= 1'b0;
      ia_o        <= 1'b0;
      is_o        <= 1'b0;
      pop_o       <= 1'b0;
      top_o       <= '0;
      empty_idx_o <= '0;
    end else begin
      done_o     <= valid_i;
      flags_we_o <= valid_i & we_d;
      of_clr_o   <= valid_i;
      c1_clr_o   <= valid_i;
      ia_o       <= valid_i & ia_d;
      is_o       <= valid_i & underflow_i;
      pop_o      <= valid_i & pop_i;
      if (valid_i) begin
        {zf_o, pf_o, cf_o} <= flags_d;
        top_o       <= top_i + TW'(1);
        empty_idx_o <= top_i;
      end
    end
  end
endmodule

// File: rtl/fcmp_flags_unit_chk.sv
module fcmp_flags_unit_chk #(
  parameter int unsigned TW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          pop_i,
  input logic          inv_mask_i,
  input logic          done_o,
  input logic          flags_we_o,
  input logic          zf_o,
  input logic          pf_o,
  input logic          cf_o,
  input logic          of_clr_o,
  input logic          c1_clr_o,
  input logic          ia_o,
  input logic          is_o,
  input logic          pop_o,
  input logic [TW-1:0] top_o,
  input logic [TW-1:0] empty_idx_o
);
  assert_code_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_we_o |-> ({zf_o, pf_o, cf_o} inside {3'b000, 3'b001, 3'b100, 3'b111}));

  assert_mask_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (ia_o || is_o)) |-> (flags_we_o == $past(inv_mask_i)));

  assert_masked_unord_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_we_o && (ia_o || is_o)) |-> (zf_o && pf_o && cf_o));

  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (of_clr_o && c1_clr_o));

  assert_pop_ptr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |-> (top_o == empty_idx_o + TW'(1)));

  assert_pop_req_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (pop_o == $past(pop_i)));

  assert_uf_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_o |-> !ia_o);

  assert_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  assert_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!done_o && !flags_we_o && !pop_o && !ia_o && !is_o));
endmodule

bind fcmp_flags_unit fcmp_flags_unit_chk #(.TW(TW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .pop_i      (pop_i),
  .inv_mask_i (inv_mask_i),
  .done_o     (done_o),
  .flags_we_o (flags_we_o),
  .zf_o       (zf_o),
  .pf_o       (pf_o),
  .cf_o       (cf_o),
  .of_clr_o   (of_clr_o),
  .c1_clr_o   (c1_clr_o),
  .ia_o       (ia_o),
  .is_o       (is_o),
  .pop_o      (pop_o),
  .top_o      (top_o),
  .empty_idx_o(empty_idx_o)
);

// File: tb/sim_fcmp_flags_unit.sv
module sim_fcmp_flags_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  localparam int VW = 167;

  localparam logic [79:0] P1   = {1'b0, 15'h3fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] P2   = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
  localparam logic [79:0] N1   = {1'b1, 15'h3fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] N2   = {1'b1, 15'h4000, 64'h8000_0000_0000_0000};
  localparam logic [79:0] PZ   = 80'h0;
  localparam logic [79:0] NZ   = {1'b1, 79'h0};
  localparam logic [79:0] QN   = {1'b0, 15'h7fff, 64'hC000_0000_0000_0000};
  localparam logic [79:0] SN   = {1'b0, 15'h7fff, 64'h8000_0000_0000_0001};
  localparam logic [79:0] INF  = {1'b0, 15'h7fff, 64'h8000_0000_0000_0000};
  localparam logic [79:0] PINF = {1'b0, 15'h7fff, 64'h0};
  localparam logic [79:0] UNN  = {1'b0, 15'h3fff, 64'h4000_0000_0000_0000};
  localparam logic [79:0] DEN1 = {1'b0, 15'h0000, 64'h0000_0000_0000_0001};
  localparam logic [79:0] DEN2 = {1'b0, 15'h0000, 64'h0000_0000_0000_0002};
  localparam logic [79:0] NDEN = {1'b1, 15'h0000, 64'h0000_0000_0000_0002};

  // {a, b, unord, mask, zpc, we, ia}
  localparam logic [VW-1:0] VEC [NV] = '{
    {P2,   P1,   1'b0, 1'b1, 3'b000, 1'b1, 1'b0},  // R1 greater
    {P1,   P2,   1'b0, 1'b1, 3'b001, 1'b1, 1'b0},  // R1 less
    {P1,   P1,   1'b1, 1'b1, 3'b100, 1'b1, 1'b0},  // R1 equal
    {PZ,   NZ,   1'b0, 1'b0, 3'b100, 1'b1, 1'b0},  // R2
    {NZ,   PZ,   1'b1, 1'b0, 3'b100, 1'b1, 1'b0},  // R2
    {N1,   N2,   1'b0, 1'b1, 3'b000, 1'b1, 1'b0},  // R11 negatives
    {N2,   P1,   1'b0, 1'b1, 3'b001, 1'b1, 1'b0},  // R11 signs
    {DEN2, DEN1, 1'b0, 1'b1, 3'b000, 1'b1, 1'b0},  // R11 denormals
    {NDEN, NZ,   1'b0, 1'b1, 3'b001, 1'b1, 1'b0},  // R11 neg denormal vs zero
    {INF,  P2,   1'b0, 1'b1, 3'b000, 1'b1, 1'b0},  // R11 infinity
    {P1,   INF,  1'b1, 1'b1, 3'b001, 1'b1, 1'b0},  // R11 infinity
    {QN,   P1,   1'b0, 1'b1, 3'b111, 1'b1, 1'b1},  // R3 qnan ordered
    {QN,   P1,   1'b1, 1'b1, 3'b111, 1'b1, 1'b0},  // R4 qnan silent
    {P1,   SN,   1'b1, 1'b1, 3'b111, 1'b1, 1'b1},  // R4 snan
    {UNN,  P1,   1'b1, 1'b0, 3'b000, 1'b0, 1'b1},  // R9 unnormal, R5 unmasked
    {SN,   P1,   1'b0, 1'b0, 3'b000, 1'b0, 1'b1},  // R3, R5 unmasked
    {PINF, P1,   1'b0, 1'b1, 3'b111, 1'b1, 1'b1},  // R9 pseudo-infinity
    {P1,   QN,   1'b0, 1'b0, 3'b000, 1'b0, 1'b1}   // R3, R5
  };

  logic        clk_i = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [79:0] op_a_i = '0, op_b_i = '0;
  logic        unord_i = 1'b0, pop_i = 1'b0, inv_mask_i = 1'b0, underflow_i = 1'b0;
  logic [2:0]  top_i = '0;
  logic        done_o, flags_we_o, zf_o, pf_o, cf_o, of_clr_o, c1_clr_o, ia_o, is_o, pop_o;
  logic [2:0]  top_o, empty_idx_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fcmp_flags_unit u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [79:0] a, input logic [79:0] b, input logic un,
                       input logic pp, input logic msk, input logic uf, input logic [2:0] tp);
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; unord_i = un; pop_i = pp; inv_mask_i = msk;
    underflow_i = uf; top_i = tp; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [VW-1:0] v;
    repeat (3) @(negedge clk_i);
    // reset state
    chk(!done_o && !flags_we_o && !pop_o, "R10 reset outputs", {5'b0, done_o, flags_we_o, pop_o}, 8'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      issue(v[166:87], v[86:7], v[6], 1'b0, v[5], 1'b0, 3'd0);
      chk(done_o, "R10 done", {7'b0, done_o}, 8'h1);
      chk(flags_we_o == v[1], "R5 flag write enable", {7'b0, flags_we_o}, {7'b0, v[1]});
      if (v[1])
        chk({zf_o, pf_o, cf_o} == v[4:2], "R1 flags", {5'b0, zf_o, pf_o, cf_o}, {5'b0, v[4:2]});
      chk(ia_o == v[0], "R3/R4 invalid", {7'b0, ia_o}, {7'b0, v[0]});
      chk(of_clr_o && c1_clr_o, "R6 clear pulses", {6'b0, of_clr_o, c1_clr_o}, 8'h3);
      chk(!pop_o, "R7 no pop", {7'b0, pop_o}, 8'h0);
    end

    // R10: idle cycle after a compare
    @(negedge clk_i);
    chk(!done_o && !flags_we_o && !of_clr_o, "R10 idle", {5'b0, done_o, flags_we_o, of_clr_o}, 8'h0);

    // R7: pop with wrap
    issue(P1, P2, 1'b0, 1'b1, 1'b1, 1'b0, 3'd7);
    chk(pop_o, "R7 pop", {7'b0, pop_o}, 8'h1);
    chk(top_o == 3'd0, "R7 top wrap", {5'b0, top_o}, 8'h0);
    chk(empty_idx_o == 3'd7, "R7 empty index", {5'b0, empty_idx_o}, 8'h7);
    chk({zf_o, pf_o, cf_o} == 3'b001, "R1 flags with pop", {5'b0, zf_o, pf_o, cf_o}, 8'h1);
    issue(P2, P1, 1'b1, 1'b1, 1'b1, 1'b0, 3'd2);
    chk(top_o == 3'd3 && empty_idx_o == 3'd2, "R7 top advance", {2'b0, top_o, empty_idx_o}, 8'h1a);

    // R8: underflow unmasked then masked
    issue(P2, P1, 1'b0, 1'b0, 1'b0, 1'b1, 3'd0);
    chk(is_o && !ia_o, "R8 underflow flag", {6'b0, is_o, ia_o}, 8'h2);
    chk(!flags_we_o, "R8 unmasked no write", {7'b0, flags_we_o}, 8'h0);
    chk(of_clr_o && c1_clr_o, "R6 clear on underflow", {6'b0, of_clr_o, c1_clr_o}, 8'h3);
    issue(QN, P1, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0);
    chk(is_o && !ia_o && flags_we_o, "R8 masked write", {5'b0, is_o, ia_o, flags_we_o}, 8'h5);
    chk({zf_o, pf_o, cf_o} == 3'b111, "R8 masked flags", {5'b0, zf_o, pf_o, cf_o}, 8'h7);

    // R9: quiet vs signalling split on fraction bit 62 in unordered flavour
    issue({1'b1, 15'h7fff, 64'hC000_0000_0000_0005}, N1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    chk(!ia_o && flags_we_o, "R9 quiet nan", {6'b0, ia_o, flags_we_o}, 8'h1);
    issue({1'b1, 15'h7fff, 64'h8400_0000_0000_0000}, N1, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0);
    chk(ia_o && !flags_we_o, "R9 signalling nan", {6'b0, ia_o, flags_we_o}, 8'h2);

    // R10: no result without a strobe
    repeat (2) @(negedge clk_i);
    chk(!done_o && !pop_o && !is_o && !ia_o, "R10 quiet bus", {4'b0, done_o, pop_o, is_o, ia_o}, 8'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule